// File: doc/BRIEF.md
# Stoppable Programmable Clock Controller

This block governs a ring oscillator whose frequency follows two configuration words. One word marks which of the ring's stages start out holding a token. The other marks which stages are in the loop. A processor asks for a new frequency by raising a change request with a frequency code, or asks for the clock to be held by raising a pause request. Each request gets one acknowledge. Both acknowledges follow a four-phase request/acknowledge handshake.

The controller counts transitions of the ring output. It raises a registered stop only on a falling ring edge, and only once enough transitions have been counted. Stop freezes the ring and gates the delivered clock low. A new code is applied only while stop is high. Stop is then released, and only after that is the change acknowledged. A pause is acknowledged while the clock is held, and the clock resumes when the request is withdrawn. The delivered clock never has a shortened high or low phase.

Both requests pass through two-flop synchronizers. Pause takes priority when both are seen in the same cycle. The ring output is taken to be in the controller's clock domain.

Top module: `stop_clk_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released: stop_o, clk_o, chg_done_o and pause_done_o are 0, and the words are the code-0 entries of R2.
- R2: Let S be the number of stages and F=(S-1)/2. For code k<F, all S stages are active (stg_word_o bits 0..S-1 set) and tokens occupy bits 0..S-2-2k. For k>=F, bits 0..S-2 are active and tokens occupy bits 0..t-1, with t=S-3-2(k-F) and never less than 2. All remaining bits are 0.
- R3: If pause and change requests are first seen in the same cycle, only the pause is served. pause_done_o responds, chg_done_o stays 0 and the words do not change.
- R4: stop_o rises only after at least REF_EDGES ring transitions have occurred since the request was raised, and only on a falling ring edge. clk_o is 0 whenever stop_o is 1.
- R5: Each high phase and each low phase of clk_o lasts at least the half-period programmed by the current words.
- R6: For a pause, pause_done_o rises PAUSE_DLY+1 cycles after stop_o rises. stop_o stays high while pause_done_o is high. After the request drops, both fall and clk_o toggles again.
- R7: A change applies the code present when the request is accepted; later changes on freq_code_i are ignored. The words change only while stop_o is 1. stop_o stays high for CHG_DLY+2 cycles. chg_done_o rises one cycle after stop_o falls.
- R8: An acknowledge stays at 1 as long as its request is held. It returns to 0 within four cycles of the request dropping, and the next request is accepted only after that.
- R9: chg_done_o and pause_done_o are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | controller clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| freq_code_i | input | CODE_W | frequency code |
| chg_req_i | input | 1 | change-frequency request |
| pause_req_i | input | 1 | pause request |
| ring_i | input | 1 | ring oscillator output |
| tok_word_o | output | STAGES | initial token pattern, bit per stage |
| stg_word_o | output | STAGES | active stage mask |
| stop_o | output | 1 | freezes the ring |
| clk_o | output | 1 | gated clock delivered to the chip |
| chg_done_o | output | 1 | change acknowledge |
| pause_done_o | output | 1 | pause acknowledge |

## Verification
The bench measures every clk_o phase against the half-period implied by the live words. A controller that stopped on a rising edge, or that released stop mid-phase, would produce a short pulse here. The bench also times stop and each acknowledge to the cycle. An early acknowledge, or words loaded before stop, would show up as a wrong count or as words that move while the clock runs. Further tests move the code after a change has been accepted, which catches a controller that samples the code late. They raise both requests at once, which catches wrong priority, and hold each request long, which catches an acknowledge that drops too soon.

// File: rtl/psc_pkg.sv
package psc_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ARM, S_LOAD, S_WAIT, S_REL, S_ACK
  } ctl_state_e;

  typedef enum logic {
    OP_PAUSE, OP_CHG
  } ctl_op_e;
endpackage

// File: rtl/psc_sync.sv
module psc_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/psc_lut.sv
module psc_lut #(
  parameter int STAGES = 11,
  parameter int CODE_W = 3
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [STAGES-1:0] tok_o,
  output logic [STAGES-1:0] stg_o
);
  localparam int FULL = (STAGES - 1) / 2;

  int n_act, n_tok, k;

  always_comb begin
    k = int'(code_i);
    if (k < FULL) begin
      n_act = STAGES;
      n_tok = STAGES - 1 - 2 * k;
    end else begin
      n_act = STAGES - 1;
      n_tok = STAGES - 3 - 2 * (k - FULL);
    end
    if (n_tok < 2) n_tok = 2;
    if (n_tok > n_act - 1) n_tok = n_act - 1;
    for (int i = 0; i < STAGES; i++) begin
      stg_o[i] = (i < n_act);
      tok_o[i] = (i < n_tok);
    end
  end
endmodule

// File: rtl/psc_edge_cnt.sv
module psc_edge_cnt #(
  parameter int REF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ring_i,
  output logic eq_o
);
  localparam int CW = $clog2(REF + 1);

  logic          ring_q;
  logic [CW-1:0] cnt_q;
  logic          edge_w, fall_w;

  assign edge_w = ring_i ^ ring_q;
  assign fall_w = ring_q & ~ring_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ring_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      ring_q <= ring_i;
      if (!en_i) cnt_q <= '0;
      else if (edge_w && cnt_q != CW'(REF)) cnt_q <= cnt_q + 1'b1;
    end
  end

  // stop only when the counted edge leaves the ring low
  assign eq_o = en_i & fall_w & (cnt_q >= CW'(REF - 1));
endmodule

// File: rtl/psc_delay.sv
module psc_delay #(
  parameter int DLY = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  localparam int DW = $clog2(DLY + 1);

  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!start_i) cnt_q <= '0;
    else if (cnt_q != DW'(DLY)) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = start_i & (cnt_q == DW'(DLY));
endmodule

// File: rtl/stop_clk_ctrl.sv
module stop_clk_ctrl
  import psc_pkg::*;
#(
  parameter int STAGES    = 11,
  parameter int CODE_W    = 3,
  parameter int REF_EDGES = 4,
  parameter int PAUSE_DLY = 3,
  parameter int CHG_DLY   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] freq_code_i,
  input  logic              chg_req_i,
  input  logic              pause_req_i,
  input  logic              ring_i,
  output logic [STAGES-1:0] tok_word_o,
  output logic [STAGES-1:0] stg_word_o,
  output logic              stop_o,
  output logic              clk_o,
  output logic              chg_done_o,
  output logic              pause_done_o
);
  ctl_state_e        state_q;
  ctl_op_e           op_q;
  logic [CODE_W-1:0] pend_code_q, cur_code_q;
  logic              stop_q, out_q, cfd_q, pcd_q;
  logic [1:0]        req_s;
  logic              pause_s, chg_s, eq_w, pdone_w, cdone_w;

  psc_sync #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({pause_req_i, chg_req_i}),
    .q_o   (req_s)
  );
  assign pause_s = req_s[1];
  assign chg_s   = req_s[0];

  psc_lut #(.STAGES(STAGES), .CODE_W(CODE_W)) u_lut (
    .code_i(cur_code_q),
    .tok_o (tok_word_o),
    .stg_o (stg_word_o)
  );

  psc_edge_cnt #(.REF(REF_EDGES)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (state_q == S_ARM),
    .ring_i(ring_i),
    .eq_o  (eq_w)
  );

  psc_delay #(.DLY(PAUSE_DLY)) u_pdly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(state_q == S_WAIT && op_q == OP_PAUSE),
    .done_o (pdone_w)
  );

  psc_delay #(.DLY(CHG_DLY)) u_cdly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(state_q == S_WAIT && op_q == OP_CHG),
    .done_o (cdone_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      op_q        <= OP_PAUSE;
      pend_code_q <= '0;
      cur_code_q  <= '0;
      stop_q      <= 1'b0;
      cfd_q       <= 1'b0;
      pcd_q       <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (pause_s) begin
            op_q    <= OP_PAUSE;
            state_q <= S_ARM;
          end else if (chg_s) begin
            op_q        <= OP_CHG;
            pend_code_q <= freq_code_i;
            state_q     <= S_ARM;
          end
        end
        S_ARM: begin
          if (eq_w) begin
            stop_q  <= 1'b1;
            state_q <= (op_q == OP_CHG) ? S_LOAD : S_WAIT;
          end
        end
        S_LOAD: begin
          cur_code_q <= pend_code_q;
          state_q    <= S_WAIT;
        end
        S_WAIT: begin
          if (pdone_w) begin
            pcd_q   <= 1'b1;
            state_q <= S_ACK;
          end else if (cdone_w) begin
            stop_q  <= 1'b0;
            state_q <= S_REL;
          end
        end
        S_REL: begin
          cfd_q   <= 1'b1;
          state_q <= S_ACK;
        end
        S_ACK: begin
          if (op_q == OP_PAUSE && !pause_s) begin
            pcd_q   <= 1'b0;
            stop_q  <= 1'b0;
            state_q <= S_IDLE;
          end else if (op_q == OP_CHG && !chg_s) begin
            cfd_q   <= 1'b0;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // registered gate: forced low from the stopping edge on
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else         out_q <= (stop_q | eq_w) ? 1'b0 : ring_i;
  end

  assign stop_o       = stop_q;
  assign clk_o        = out_q;
  assign chg_done_o   = cfd_q;
  assign pause_done_o = pcd_q;
endmodule

// File: rtl/stop_clk_ctrl_chk.sv
module stop_clk_ctrl_chk #(
  parameter int STAGES = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [STAGES-1:0] tok_word_o,
  input logic [STAGES-1:0] stg_word_o,
  input logic              stop_o,
  input logic              clk_o,
  input logic              chg_done_o,
  input logic              pause_done_o
);
  a_r4_stop_holds_clk_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> !clk_o);

  a_r7_words_move_only_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(tok_word_o) || !$stable(stg_word_o)) |-> stop_o);

  a_r6_pause_ack_while_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_done_o |-> stop_o);

  a_r7_chg_ack_after_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chg_done_o) |-> (!stop_o && $past(stop_o, 2)));

  a_r9_acks_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(chg_done_o && pause_done_o));
endmodule

bind stop_clk_ctrl stop_clk_ctrl_chk #(.STAGES(STAGES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tok_word_o  (tok_word_o),
  .stg_word_o  (stg_word_o),
  .stop_o      (stop_o),
  .clk_o       (clk_o),
  .chg_done_o  (chg_done_o),
  .pause_done_o(pause_done_o)
);

// File: tb/stop_clk_ctrl_bench.sv
module stop_clk_ctrl_bench;
  localparam int S     = 11;
  localparam int CW    = 3;
  localparam int REF   = 4;
  localparam int PDLY  = 3;
  localparam int CDLY  = 4;
  localparam int F     = (S - 1) / 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] fc = '0;
  logic          cf = 1'b0, pc = 1'b0, ring = 1'b0;
  logic [S-1:0]  tok, stg;
  logic          stop, clk_g, cfd, pcd;

  int errors = 0, checks = 0;
  int ring_edges = 0, clk_edges = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  stop_clk_ctrl #(.STAGES(S), .CODE_W(CW), .REF_EDGES(REF),
                  .PAUSE_DLY(PDLY), .CHG_DLY(CDLY)) u_stop_clk_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .freq_code_i(fc), .chg_req_i(cf),
    .pause_req_i(pc), .ring_i(ring), .tok_word_o(tok), .stg_word_o(stg),
    .stop_o(stop), .clk_o(clk_g), .chg_done_o(cfd), .pause_done_o(pcd)
  );

  function automatic logic [S-1:0] exp_stg(int k);
    int n = (k < F) ? S : S - 1;
    logic [S-1:0] m = '0;
    for (int i = 0; i < n; i++) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [S-1:0] exp_tok(int k);
    int t = (k < F) ? S - 1 - 2 * k : S - 3 - 2 * (k - F);
    logic [S-1:0] m = '0;
    if (t < 2) t = 2;
    for (int i = 0; i < t; i++) m[i] = 1'b1;
    return m;
  endfunction

  // ring model: half-period from the live words
  function automatic int half_of(logic [S-1:0] tw, logic [S-1:0] sw);
    int nt = $countones(tw & sw);
    int ns = $countones(sw);
    int d  = (2 * nt > ns) ? 2 * nt - ns : ns - 2 * nt;
    return 2 + d / 2;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin : ring_model
    int ph = 0;
    forever begin
      @(negedge clk);
      if (!rst_n || stop) begin
        ring = 1'b0;
        ph = 0;
      end else begin
        ph++;
        if (ph >= half_of(tok, stg)) begin
          ring = ~ring;
          ph = 0;
          ring_edges++;
        end
      end
    end
  end

  initial begin : monitor
    int run = 0;
    logic prev_clk = 1'b0;
    logic [S-1:0] prev_tok = '0, prev_stg = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        run = 0; prev_clk = 1'b0; prev_tok = tok; prev_stg = stg;
      end else begin
        chk(!(stop && clk_g), "R4 clk low while stopped", int'(clk_g), 0);
        chk(!(cfd && pcd), "R9 acks exclusive", int'(cfd) + int'(pcd), 1);
        if ((tok != prev_tok || stg != prev_stg) && !stop)
          chk(0, "R7 words moved while running", int'(stop), 1);
        if (clk_g != prev_clk) begin
          clk_edges++;
          if (run > 0) chk(run >= half_of(tok, stg), "R5 phase length", run, half_of(tok, stg));
          run = 1;
        end else begin
          run++;
        end
        prev_clk = clk_g; prev_tok = tok; prev_stg = stg;
      end
    end
  end

  task automatic do_pause();
    int n, e0;
    logic [S-1:0] t0;
    e0 = ring_edges; t0 = tok;
    @(negedge clk); pc = 1'b1;
    n = 0;
    while (!stop && n < 500) begin @(negedge clk); n++; end
    chk(stop, "R4 pause stops", int'(stop), 1);
    chk(ring_edges - e0 >= REF, "R4 edges before stop", ring_edges - e0, REF);
    n = 0;
    while (!pcd && n < 50) begin @(negedge clk); n++; end
    chk(n == PDLY + 1, "R6 pause ack latency", n, PDLY + 1);
    repeat (12) @(negedge clk);
    chk(pcd && stop, "R8 pause ack held", int'(pcd), 1);
    chk(tok == t0, "R6 words kept on pause", int'(tok), int'(t0));
    pc = 1'b0;
    repeat (4) @(negedge clk);
    chk(!pcd && !stop, "R8 pause ack released", int'(pcd) + int'(stop), 0);
    e0 = clk_edges;
    repeat (40) @(negedge clk);
    chk(clk_edges > e0, "R6 clock resumes", clk_edges - e0, 1);
  endtask

  task automatic do_change(int code, int late);
    int n, e0;
    logic [S-1:0] t0, s0;
    e0 = ring_edges; t0 = tok; s0 = stg;
    @(negedge clk); fc = CW'(code); cf = 1'b1;
    n = 0;
    while (!stop && n < 500) begin @(negedge clk); n++; end
    chk(stop, "R4 change stops", int'(stop), 1);
    chk(ring_edges - e0 >= REF, "R4 edges before stop", ring_edges - e0, REF);
    chk(tok == t0 && stg == s0, "R7 words held until stopped", int'(tok), int'(t0));
    fc = CW'(late);
    n = 0;
    while (stop && n < 100) begin n++; @(negedge clk); end
    chk(n == CDLY + 2, "R7 stop duration", n, CDLY + 2);
    chk(!cfd, "R7 ack not with release", int'(cfd), 0);
    @(negedge clk);
    chk(cfd, "R7 ack one cycle after release", int'(cfd), 1);
    chk(tok == exp_tok(code), "R2 token word", int'(tok), int'(exp_tok(code)));
    chk(stg == exp_stg(code), "R2 stage word", int'(stg), int'(exp_stg(code)));
    repeat (10) @(negedge clk);
    chk(cfd, "R8 change ack held", int'(cfd), 1);
    chk(tok == exp_tok(code), "R7 late code ignored", int'(tok), int'(exp_tok(code)));
    cf = 1'b0;
    repeat (4) @(negedge clk);
    chk(!cfd, "R8 change ack released", int'(cfd), 0);
    repeat (30) @(negedge clk);
  endtask

  task automatic do_both();
    int n;
    logic [S-1:0] t0;
    t0 = tok;
    @(negedge clk); fc = CW'(6); cf = 1'b1; pc = 1'b1;
    n = 0;
    while (!pcd && n < 500) begin @(negedge clk); n++; end
    chk(pcd, "R3 pause wins", int'(pcd), 1);
    chk(!cfd, "R3 no change ack", int'(cfd), 0);
    pc = 1'b0; cf = 1'b0;
    repeat (8) @(negedge clk);
    chk(!cfd && !pcd, "R3 both acks low", int'(cfd) + int'(pcd), 0);
    chk(tok == t0, "R3 words unchanged", int'(tok), int'(t0));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk(!stop && !clk_g && !cfd && !pcd, "R1 outputs in reset",
        int'(stop) + int'(clk_g) + int'(cfd) + int'(pcd), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tok == exp_tok(0), "R1 token word", int'(tok), int'(exp_tok(0)));
    chk(stg == exp_stg(0), "R1 stage word", int'(stg), int'(exp_stg(0)));
    repeat (60) @(negedge clk);
    do_change(2, 7);
    do_pause();
    do_change(5, 0);
    do_change(7, 1);
    do_both();
    do_change(0, 3);
    do_pause();
    repeat (40) @(negedge clk);
    done_flag = 1;
    summary();
    $finish;
  end
endmodule